// File: doc/BRIEF.md
# DDR Activate Spacing Gate

This block sits on the controller side of a four-bank DDR SDRAM and decides, cycle by cycle, whether the command a scheduler is asking for may go to the memory yet. The scheduler offers one request per clock: a bank activate with a row address, a column read or write with a column address, or nothing. The gate passes a request through only once two spacing minimums hold. The first is the delay from a bank's activate to a column access on that bank. The second is the spacing between any two activates. In every cycle where nothing legal can go out, the gate drives a no-operation instead.

Both minimums are elaboration parameters in picoseconds, together with the clock period. The gate turns them into whole cycles by rounding up, so a minimum worth 2.5 periods costs three cycles. A request that must wait is not lost. The gate holds `req_ready` low, and the scheduler keeps the same request on its inputs until `req_ready` rises. A column access to a bank whose row was never opened is refused. It is consumed with an error pulse and never reaches the memory.

Top module: `ddr_act_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_out` is no-operation, `err_no_row` is low, and `bank_out` and `addr_out` are zero.
- R2: Each minimum in cycles is the ceiling of its picosecond value divided by the clock period, and never less than 1. With the defaults (10000 ps clock, 25000 ps activate-to-column, 15000 ps activate-to-activate) the results are 3 and 2 cycles.
- R3: A read or write to a bank is issued no earlier than the activate-to-column cycle count after that bank's last activate was issued. It is issued in exactly the first cycle where that holds.
- R4: Two issued activates, to any banks, are at least the activate-to-activate cycle count apart. A waiting activate goes out in the first cycle that meets the spacing.
- R5: While a request cannot legally be issued, `req_ready` is low and `cmd_out` stays no-operation. Once the request is legal, `req_ready` is high in that same cycle, and the request is issued with its bank and address unchanged.
- R6: A read or write to a bank with no activated row makes `req_ready` high. In the following cycle, `err_no_row` pulses high for one cycle and `cmd_out` is no-operation.
- R7: A request accepted at a clock edge appears on `cmd_out`, `bank_out` and `addr_out` registered, in the cycle after that edge. In every cycle where nothing is issued, `cmd_out` is no-operation and `bank_out` and `addr_out` are zero.
- R8: Command encoding on `req_cmd` and `cmd_out` is 2'b00 no-operation, 2'b01 activate, 2'b10 read, 2'b11 write. The bank is 2 bits and selects one of four banks. The 13-bit address carries the row with an activate and the column with a read or write. An idle input (`req_valid` low) and an explicit no-operation request are both accepted at once.
- R9: Each bank keeps its own activate-to-column timer. An activate to one bank does not delay a column access to another bank whose delay has already elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_cmd | input | 2 | Requested command (R8 encoding) |
| req_bank | input | 2 | Requested bank |
| req_addr | input | 13 | Row for activate, column for read or write |
| req_ready | output | 1 | Request is taken at the next edge; low while it must wait |
| cmd_out | output | 2 | Command sent to the memory |
| bank_out | output | 2 | Bank sent with the command |
| addr_out | output | 13 | Address sent with the command |
| err_no_row | output | 1 | One-cycle pulse: column access to a bank without an open row was refused |

## Verification
`req_ready` is combinational, so it reflects the offered request in the cycle the request is offered. The command the gate takes at an edge shows on the outputs one cycle later. The driver works out from its own model the edge at which each request must be accepted: the later of the next edge and the bank's or the device's last activate plus the rounded cycle count. Before each edge it checks that `req_ready` is high only at the predicted edge. It queues the expected output for that edge, and the monitor samples at the falling edge. There it compares the queue head when the head is due, and otherwise requires an idle no-operation output.

// File: rtl/ddr_act_gate_pkg.sv
// Shared command encoding and time-to-cycle conversion for the activate gate.
// Assumes all times are whole picoseconds and the clock period is non-zero.
package ddr_act_gate_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RD  = 2'b10,
        CMD_WR  = 2'b11
    } cmd_e;

    // R2: round a picosecond minimum up to whole clock cycles, at least one
    function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/ddr_bank_timer.sv
// Per-bank activate-to-column timer and open-row flag.
// Loads LOAD-1 when an activate is issued to this bank and counts down to zero.
// A column access is legal once the row is open and the count is zero.
// Assumes LOAD >= 1 and that only one command is issued per cycle.
module ddr_bank_timer #(
    parameter int LOAD  = 3,
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic open_o,
    output logic col_ok_o
);

    logic [CNT_W-1:0] cnt;

    // Count the activate-to-column window down after each activate.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (act_i)             cnt <= CNT_W'(LOAD - 1);
        else if (cnt != '0)         cnt <= cnt - 1'b1;
    end

    // Remember that a row has been opened in this bank.
    always_ff @(posedge clk) begin
        if (!rst_n)      open_o <= 1'b0;
        else if (act_i)  open_o <= 1'b1;
    end

    // Column access legal only with an open row and an expired window.
    always_comb col_ok_o = open_o && (cnt == '0);

    // R3
    rcd_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !act_i) |=> (cnt == $past(cnt) - 1'b1));

    generate
        if (LOAD > 1) begin : g_block_chk
            // R3
            rcd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                act_i |=> (open_o && !col_ok_o));
        end
    endgenerate

endmodule

// File: rtl/ddr_rrd_timer.sv
// Device-wide activate-to-activate timer.
// Loads LOAD-1 whenever any activate is issued; a new activate is legal at zero.
// Assumes LOAD >= 1.
module ddr_rrd_timer #(
    parameter int LOAD  = 2,
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic act_ok_o
);

    logic [CNT_W-1:0] cnt;

    // Count the spacing window down after every issued activate.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (act_i)      cnt <= CNT_W'(LOAD - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Next activate allowed once the window has run out.
    always_comb act_ok_o = (cnt == '0);

    // R4
    rrd_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !act_i) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr_act_gate.sv
// Activate spacing gate for a four-bank DDR SDRAM, controller side.
// Passes a requested command to the memory only when the activate-to-column
// and activate-to-activate minimums hold; drives no-operation otherwise.
// Assumes the requester holds its request stable while req_ready is low.
module ddr_act_gate
    import ddr_act_gate_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int CLK_PS    = 10000,
    parameter int TRCD_PS   = 25000,
    parameter int TRRD_PS   = 15000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_cmd,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         req_ready,
    output logic [1:0]                   cmd_out,
    output logic [$clog2(NUM_BANKS)-1:0] bank_out,
    output logic [ADDR_W-1:0]            addr_out,
    output logic                         err_no_row
);

    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int RCD_CYC = ps_to_cycles(TRCD_PS, CLK_PS);
    localparam int RRD_CYC = ps_to_cycles(TRRD_PS, CLK_PS);
    localparam int MAX_CYC = (RCD_CYC > RRD_CYC) ? RCD_CYC : RRD_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] bank_col_ok;
    logic [NUM_BANKS-1:0] bank_act;
    logic                 act_ok;
    logic                 want_act;
    logic                 want_col;
    logic                 no_row;
    logic                 issue_act;
    logic                 issue_col;

    // Decode the offered request.
    always_comb begin
        want_act = req_valid && (req_cmd == CMD_ACT);
        want_col = req_valid && req_cmd[1];
        no_row   = want_col && !bank_open[req_bank];
    end

    // Decide what is legal this cycle and whether the request is taken.
    always_comb begin
        issue_act = want_act && act_ok;
        issue_col = want_col && bank_open[req_bank] && bank_col_ok[req_bank];
        if (want_act)      req_ready = act_ok;
        else if (want_col) req_ready = no_row || bank_col_ok[req_bank];
        else               req_ready = 1'b1;
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Steer an issued activate to its bank timer.
            always_comb bank_act[b] = issue_act && (req_bank == BANK_W'(b));

            ddr_bank_timer #(.LOAD(RCD_CYC), .CNT_W(CNT_W)) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_i    (bank_act[b]),
                .open_o   (bank_open[b]),
                .col_ok_o (bank_col_ok[b])
            );
        end
    endgenerate

    ddr_rrd_timer #(.LOAD(RRD_CYC), .CNT_W(CNT_W)) u_rrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (issue_act),
        .act_ok_o (act_ok)
    );

    // Register the command sent to the memory, no-operation when nothing goes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_out    <= CMD_NOP;
            bank_out   <= '0;
            addr_out   <= '0;
            err_no_row <= 1'b0;
        end else begin
            err_no_row <= no_row;
            if (issue_act || issue_col) begin
                cmd_out  <= req_cmd;
                bank_out <= req_bank;
                addr_out <= req_addr;
            end else begin
                cmd_out  <= CMD_NOP;
                bank_out <= '0;
                addr_out <= '0;
            end
        end
    end

    // R6
    err_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_row |-> (cmd_out == CMD_NOP));

    // R5
    stall_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (cmd_out == CMD_NOP));

    generate
        if (RRD_CYC > 1) begin : g_rrd_chk
            // R4
            act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_out == CMD_ACT) |=> (cmd_out != CMD_ACT));
        end
    endgenerate

endmodule

// File: tb/tb_ddr_act_gate.sv
module tb_ddr_act_gate;

    localparam int CLK_PS  = 10000;
    localparam int TRCD_PS = 25000;
    localparam int TRRD_PS = 15000;
    // R2: bench's own rounding, 2.5 periods -> 3 cycles, 1.5 periods -> 2 cycles
    localparam int RCD = (TRCD_PS + CLK_PS - 1) / CLK_PS;
    localparam int RRD = (TRRD_PS + CLK_PS - 1) / CLK_PS;

    localparam logic [1:0] NOP = 2'b00, ACT = 2'b01, RD = 2'b10, WR = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic [1:0]  req_bank = 2'b00;
    logic [12:0] req_addr = '0;
    logic        req_ready;
    logic [1:0]  cmd_out;
    logic [1:0]  bank_out;
    logic [12:0] addr_out;
    logic        err_no_row;

    ddr_act_gate #(.CLK_PS(CLK_PS), .TRCD_PS(TRCD_PS), .TRRD_PS(TRRD_PS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
        .cmd_out(cmd_out), .bank_out(bank_out), .addr_out(addr_out),
        .err_no_row(err_no_row)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          due;
        logic [1:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    int   act_edge[4];
    bit   open_m[4];
    int   last_act = -100;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Driver: model the accept edge, queue the expected output, hold the request.
    task automatic send(input logic [1:0] c, input int b, input logic [12:0] a,
                        input string tag);
        exp_t it;
        int   e;
        bit   er;
        e  = cyc + 1;
        er = 1'b0;
        if (c == ACT) begin
            if (last_act + RRD > e) e = last_act + RRD;
            last_act = e;
            act_edge[b] = e;
            open_m[b] = 1'b1;
        end else if (c[1]) begin
            if (!open_m[b]) er = 1'b1;
            else if (act_edge[b] + RCD > e) e = act_edge[b] + RCD;
        end
        it.due  = e;
        it.cmd  = (er || c == NOP) ? NOP : c;
        it.bank = (er || c == NOP) ? 2'b00 : 2'(b);
        it.addr = (er || c == NOP) ? 13'h0 : a;
        it.err  = er;
        it.tag  = tag;
        q.push_back(it);
        req_valid = 1'b1;
        req_cmd   = c;
        req_bank  = 2'(b);
        req_addr  = a;
        #1;
        forever begin
            // R5: ready only at the predicted accept edge
            chk(req_ready == (cyc + 1 == e), "R5", "req_ready", req_ready, (cyc + 1 == e));
            if (cyc + 1 == e) break;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_cmd   = NOP;
        req_bank  = 2'b00;
        req_addr  = '0;
    endtask

    // Monitor: compare the queue head when due, else require an idle output.
    always @(negedge clk) begin
        if (mon_on) begin
            if (q.size() != 0 && q[0].due == cyc) begin
                chk(cmd_out == q[0].cmd, q[0].tag, "cmd_out", cmd_out, q[0].cmd);
                chk(bank_out == q[0].bank, q[0].tag, "bank_out", bank_out, q[0].bank);
                chk(addr_out == q[0].addr, q[0].tag, "addr_out", addr_out, q[0].addr);
                chk(err_no_row == q[0].err, q[0].tag, "err_no_row", err_no_row, q[0].err);
                void'(q.pop_front());
            end else begin
                // R7: nothing issued -> no-operation, zero bank and address
                chk(cmd_out == NOP && bank_out == 2'b00 && addr_out == 13'h0 && !err_no_row,
                    "R7", "idle output", {cmd_out, bank_out, addr_out, err_no_row}, 0);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(cmd_out == NOP && !err_no_row && bank_out == 0 && addr_out == 0,
            "R1", "reset outputs", cmd_out, NOP);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        // R1: still quiet after release
        chk(cmd_out == NOP && !err_no_row, "R1", "post-reset", cmd_out, NOP);
        send(RD, 0, 13'h0010, "R6");          // no open row -> refused
        send(NOP, 2, 13'h0123, "R8");         // explicit no-operation passes
        send(ACT, 0, 13'h1ABC, "R8");
        send(ACT, 1, 13'h0555, "R4");         // waits one cycle for spacing
        send(RD, 0, 13'h0040, "R3");          // exactly at the boundary
        send(WR, 1, 13'h0041, "R3");          // waits for bank 1 window
        send(ACT, 2, 13'h0AAA, "R4");
        send(WR, 2, 13'h07F0, "R3");          // full window stall
        idle(8);
        send(ACT, 3, 13'h1FFF, "R8");
        send(RD, 1, 13'h0002, "R9");          // other bank unaffected
        send(ACT, 0, 13'h0777, "R4");         // reopen bank 0
        send(RD, 0, 13'h0003, "R3");          // new window applies
        send(WR, 3, 13'h1FFF, "R9");
        idle(4);
        // R7: every expected output has appeared
        chk(q.size() == 0, "R7", "pending items", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule